// File: doc/BRIEF.md
# Update Pulse Output Controller

This block produces the conversion-update strobe of an analog output timing engine and drives it onto two pins: a dedicated update pin and a shared multipurpose pin. An update request, coming either from an internal source or from a one-shot software strobe bit, is shaped into a pulse. A software gate and an external gate can block the pulse. The result is then encoded into a level and a tristate enable for each pin.

Three shaping modes are available:

- **Fixed.** The pulse-timebase option is off. The pulse lasts a programmed number of clock cycles, counted from the request's rising edge.
- **Capped.** The timebase is on and the original-pulse bit is 0. The pulse follows the request but is cut off at the programmed width.
- **Follow.** The timebase is on and the original-pulse bit is 1. The pulse copies the request exactly, and the external gate is ignored.

A two-bit output-select field controls both pins. On the dedicated pin it picks high impedance, ground, active low or active high. On the shared pin it picks the polarity, and that pin's direction input decides whether the pin drives at all.

Top module: `upd_pulse_ctrl`

## Requirements
- R1: Dedicated pin, by output-select code. Code 0: enable low, level 0. Code 1: enabled, level 0. Code 2: enabled, level is the inverted pulse. Code 3: enabled, level is the pulse.
- R2: Shared pin, when its direction input is 1 (the pin is enabled). Code 1: level 0. Code 3: level is the pulse. Codes 0 and 2: level is the inverted pulse. When the direction input is 0, the shared pin's enable and level are both 0.
- R3: A write to the software strobe bit produces exactly one pulse, shaped by the current mode. In fixed mode with width W, that pulse lasts max(W,1) cycles.
- R4: The strobe readback is 1 in the cycle after a write and returns to 0 on the next cycle with no further write.
- R5: While the software gate is 1, no pulse appears in any mode. While the external gate is 1, no pulse appears in fixed or capped mode.
- R6: In fixed mode, a request rising edge starts a pulse of exactly max(W,1) cycles, whatever the length of the request.
- R7: A request edge that arrives while a pulse is active is merged into that pulse. A new pulse starts only on a rising edge seen when no pulse is active.
- R8: In capped mode, a request that is high for k cycles gives a pulse of min(k, max(W,1)) cycles.
- R9: In follow mode, a request that is high for k cycles gives a pulse of k cycles, and the external gate has no effect.
- R10: The software strobe and the internal request are ORed before shaping. If they overlap or are adjacent, they form one pulse.
- R11: During reset, both pin levels and the strobe readback are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_req_i | input | 1 | Internal update request |
| sw_strobe_wr_i | input | 1 | Write of 1 to the software strobe bit |
| ext_gate_i | input | 1 | External gate, 1 blocks |
| sw_gate_i | input | 1 | Software gate, 1 blocks |
| tbase_sel_i | input | 1 | Pulse-timebase option |
| orig_pulse_i | input | 1 | Original-pulse bit |
| width_i | input | WIDTH_W | Pulse width or cap, in cycles (0 acts as 1) |
| out_sel_i | input | 2 | Output-select code |
| mp_dir_out_i | input | 1 | Shared pin direction, 1 is output |
| sw_strobe_rd_o | output | 1 | Strobe bit readback |
| upd_pin_o | output | 1 | Dedicated pin level |
| upd_pin_oe_o | output | 1 | Dedicated pin enable |
| mp_pin_o | output | 1 | Shared pin level |
| mp_pin_oe_o | output | 1 | Shared pin enable |

## Verification
The bench builds the block with WIDTH_W = 3. This puts every width code from 0 to 7 within reach, including the zero-width case and the largest cap. It sweeps each width against request lengths of 1 to 9 cycles in all three shaping modes, so requests both shorter and longer than the cap are covered. It also sweeps all output-select codes against both directions of the shared pin and both pulse levels.

// File: rtl/upd_pulse_pkg.sv
// Shared types for the update pulse output controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package upd_pulse_pkg;

    // Output-select codes; the encoding is decoded by both pin drivers.
    typedef enum logic [1:0] {
        SEL_HIZ  = 2'd0,
        SEL_GND  = 2'd1,
        SEL_LOW  = 2'd2,
        SEL_HIGH = 2'd3
    } upd_sel_e;

    // Pulse shaping modes derived from the timebase and original-pulse bits.
    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_CAPPED = 2'd1,
        MODE_FOLLOW = 2'd2
    } shape_mode_e;

    // Pin drive pair: level and tristate enable.
    typedef struct packed {
        logic level;
        logic drive;
    } pin_drv_t;

endpackage

// File: rtl/upd_strobe_reg.sv
// Self-clearing software strobe bit.
// A write of 1 sets the bit for one cycle; it then clears without help.
// Assumes wr_i is a single-cycle write pulse from the register decoder.
module upd_strobe_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    output logic strobe_o
);

    logic strobe_q;

    // Capture the write; the bit falls again on the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= wr_i;
        end
    end

    assign strobe_o = strobe_q;

    AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && !wr_i) |=> !strobe_q); // R4

endmodule

// File: rtl/upd_pulse_shaper.sv
// Shapes the combined update trigger into the update pulse.
// Fixed mode: max(W,1) cycles from a rising edge. Capped mode: follows the
// trigger, cut at max(W,1) cycles. Follow mode: copies the trigger.
// Assumes trig_i is synchronous to clk. Gating is applied each cycle.
module upd_pulse_shaper
    import upd_pulse_pkg::*;
#(
    parameter int WIDTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_i,
    input  logic               ext_gate_i,
    input  logic               sw_gate_i,
    input  logic               tbase_sel_i,
    input  logic               orig_pulse_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               pulse_o
);

    localparam logic [WIDTH_W-1:0] ONE = {{(WIDTH_W-1){1'b0}}, 1'b1};

    shape_mode_e        mode;
    logic               blocked;
    logic               rise;
    logic [WIDTH_W-1:0] wlim;
    logic               pulse_q;
    logic               trig_d;
    logic [WIDTH_W-1:0] cnt_q;

    // Decode the shaping mode from the two configuration bits.
    always_comb begin
        if (!tbase_sel_i)      mode = MODE_FIXED;
        else if (!orig_pulse_i) mode = MODE_CAPPED;
        else                   mode = MODE_FOLLOW;
    end

    // Gating: external gate is ignored in follow mode.
    assign blocked = sw_gate_i | (ext_gate_i & (mode != MODE_FOLLOW));
    assign rise    = trig_i & ~trig_d;
    assign wlim    = (width_i == '0) ? ONE : width_i;

    // Pulse state and width counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            trig_d  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            trig_d <= trig_i;
            if (mode == MODE_FOLLOW) begin
                pulse_q <= trig_i & ~blocked;
                cnt_q   <= '0;
            end else if (blocked) begin
                pulse_q <= 1'b0;
                cnt_q   <= '0;
            end else if (pulse_q) begin
                if ((cnt_q >= wlim) || ((mode == MODE_CAPPED) && !trig_i)) begin
                    pulse_q <= 1'b0;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + ONE;
                end
            end else if (rise) begin
                pulse_q <= 1'b1;
                cnt_q   <= ONE;
            end
        end
    end

    assign pulse_o = pulse_q;

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> !pulse_q); // R5
    AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != MODE_FOLLOW) && pulse_q && $stable(width_i)) |-> (cnt_q <= wlim)); // R6
    AST_NO_EDGE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != MODE_FOLLOW) && !pulse_q && !rise) |=> !pulse_q); // R7
    AST_FOLLOW_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_FOLLOW) && trig_i && !sw_gate_i) |=> pulse_q); // R9

endmodule

// File: rtl/upd_pin_drive.sv
// Encodes the update pulse into a level and tristate enable for one pin.
// SHARED = 0 selects the dedicated-pin table, SHARED = 1 the shared-pin table.
// en_i is the pin direction: 1 allows driving. The level is 0 whenever the
// enable is 0.
module upd_pin_drive
    import upd_pulse_pkg::*;
#(
    parameter bit SHARED = 1'b0
) (
    input  logic       pulse_i,
    input  logic [1:0] sel_i,
    input  logic       en_i,
    output logic       pin_o,
    output logic       oe_o
);

    pin_drv_t drv;

    generate
        if (SHARED) begin : g_shared
            // Shared pin: code only sets polarity, direction sets enable.
            always_comb begin
                drv.drive = en_i;
                case (upd_sel_e'(sel_i))
                    SEL_GND:  drv.level = 1'b0;
                    SEL_HIGH: drv.level = pulse_i;
                    default:  drv.level = ~pulse_i;
                endcase
                if (!drv.drive) drv.level = 1'b0;
            end
        end else begin : g_dedicated
            // Dedicated pin: code 0 releases the pin, the others drive it.
            always_comb begin
                drv.drive = en_i;
                drv.level = 1'b0;
                case (upd_sel_e'(sel_i))
                    SEL_HIZ:  drv.drive = 1'b0;
                    SEL_GND:  drv.level = 1'b0;
                    SEL_LOW:  drv.level = ~pulse_i;
                    SEL_HIGH: drv.level = pulse_i;
                    default:  drv.level = 1'b0;
                endcase
                if (!drv.drive) drv.level = 1'b0;
            end
        end
    endgenerate

    assign pin_o = drv.level;
    assign oe_o  = drv.drive;

endmodule

// File: rtl/upd_pulse_ctrl.sv
// Update pulse output controller, top level.
// ORs the software strobe with the internal request, shapes and gates the
// pulse, then drives the dedicated and shared pins.
// Assumes all inputs are synchronous to clk.
module upd_pulse_ctrl
    import upd_pulse_pkg::*;
#(
    parameter int WIDTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_req_i,
    input  logic               sw_strobe_wr_i,
    input  logic               ext_gate_i,
    input  logic               sw_gate_i,
    input  logic               tbase_sel_i,
    input  logic               orig_pulse_i,
    input  logic [WIDTH_W-1:0] width_i,
    input  logic [1:0]         out_sel_i,
    input  logic               mp_dir_out_i,
    output logic               sw_strobe_rd_o,
    output logic               upd_pin_o,
    output logic               upd_pin_oe_o,
    output logic               mp_pin_o,
    output logic               mp_pin_oe_o
);

    logic strobe;
    logic trig;
    logic pulse;

    upd_strobe_reg u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (sw_strobe_wr_i),
        .strobe_o (strobe)
    );

    // Combine the two update sources before shaping.
    assign trig = strobe | upd_req_i;

    upd_pulse_shaper #(.WIDTH_W(WIDTH_W)) u_shaper (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig),
        .ext_gate_i   (ext_gate_i),
        .sw_gate_i    (sw_gate_i),
        .tbase_sel_i  (tbase_sel_i),
        .orig_pulse_i (orig_pulse_i),
        .width_i      (width_i),
        .pulse_o      (pulse)
    );

    upd_pin_drive #(.SHARED(1'b0)) u_pin_upd (
        .pulse_i (pulse),
        .sel_i   (out_sel_i),
        .en_i    (1'b1),
        .pin_o   (upd_pin_o),
        .oe_o    (upd_pin_oe_o)
    );

    upd_pin_drive #(.SHARED(1'b1)) u_pin_mp (
        .pulse_i (pulse),
        .sel_i   (out_sel_i),
        .en_i    (mp_dir_out_i),
        .pin_o   (mp_pin_o),
        .oe_o    (mp_pin_oe_o)
    );

    assign sw_strobe_rd_o = strobe;

    AST_PINS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pin_oe_o && mp_pin_oe_o) |-> (upd_pin_o == mp_pin_o)); // R2
    AST_HIZ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel_i == 2'd0) |-> (!upd_pin_oe_o && !upd_pin_o)); // R1

endmodule

// File: tb/upd_pulse_ctrl_tb.sv
module upd_pulse_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_req = 1'b0;
    logic          sw_wr = 1'b0;
    logic          ext_gate = 1'b0;
    logic          sw_gate = 1'b0;
    logic          tbase = 1'b0;
    logic          orig = 1'b0;
    logic [WW-1:0] width = '0;
    logic [1:0]    out_sel = 2'd3;
    logic          mp_dir = 1'b1;
    logic          rd, upd_o, upd_oe, mp_o, mp_oe;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    upd_pulse_ctrl #(.WIDTH_W(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .upd_req_i(upd_req), .sw_strobe_wr_i(sw_wr),
        .ext_gate_i(ext_gate), .sw_gate_i(sw_gate), .tbase_sel_i(tbase),
        .orig_pulse_i(orig), .width_i(width), .out_sel_i(out_sel),
        .mp_dir_out_i(mp_dir), .sw_strobe_rd_o(rd), .upd_pin_o(upd_o),
        .upd_pin_oe_o(upd_oe), .mp_pin_o(mp_o), .mp_pin_oe_o(mp_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // mode: 0 fixed, 1 capped, 2 follow. Counts high cycles and rising edges.
    task automatic trial(input int mode, input int w, input logic [15:0] req_pat,
                         input logic [15:0] wr_pat, input bit eg, input bit sg,
                         output int highs, output int rises);
        bit prev = 1'b0;
        highs = 0;
        rises = 0;
        @(negedge clk);
        tbase = (mode != 0);
        orig = (mode == 2);
        width = WW'(w);
        ext_gate = eg;
        sw_gate = sg;
        out_sel = 2'd3;
        mp_dir = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (upd_o) highs++;
            if (upd_o && !prev) rises++;
            prev = upd_o;
            upd_req = (i < 16) ? req_pat[i] : 1'b0;
            sw_wr = (i < 16) ? wr_pat[i] : 1'b0;
        end
        ext_gate = 1'b0;
        sw_gate = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int h, r, wl;
        repeat (3) @(negedge clk);
        // R11: reset state with both pins enabled active high
        check(upd_o == 1'b0, "R11 upd level", int'(upd_o), 0);
        check(mp_o == 1'b0, "R11 mp level", int'(mp_o), 0);
        check(rd == 1'b0, "R11 readback", int'(rd), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 R8 R9: width sweep against request length in all modes
        for (int w = 0; w < 8; w++) begin
            wl = (w == 0) ? 1 : w;
            for (int k = 1; k < 10; k++) begin
                trial(0, w, 16'((1 << k) - 1), 16'h0, 1'b0, 1'b0, h, r);
                check(h == wl && r == 1, "R6 fixed width", h, wl);
                trial(1, w, 16'((1 << k) - 1), 16'h0, 1'b0, 1'b0, h, r);
                check(h == ((k < wl) ? k : wl) && r == 1, "R8 capped width", h, (k < wl) ? k : wl);
                trial(2, w, 16'((1 << k) - 1), 16'h0, 1'b0, 1'b0, h, r);
                check(h == k && r == 1, "R9 follow width", h, k);
            end
        end

        // R7: merging and restart
        trial(0, 6, 16'b101, 16'h0, 1'b0, 1'b0, h, r);
        check(h == 6 && r == 1, "R7 merged edge", h * 10 + r, 61);
        trial(0, 2, 16'b1001, 16'h0, 1'b0, 1'b0, h, r);
        check(h == 4 && r == 2, "R7 restart after end", h * 10 + r, 42);
        trial(1, 6, 16'b10111, 16'h0, 1'b0, 1'b0, h, r);
        check(h == 4 && r == 2, "R7 capped restart", h * 10 + r, 42);

        // R3: software strobe
        trial(0, 3, 16'h0, 16'h1, 1'b0, 1'b0, h, r);
        check(h == 3 && r == 1, "R3 strobe fixed", h * 10 + r, 31);
        trial(0, 0, 16'h0, 16'h1, 1'b0, 1'b0, h, r);
        check(h == 1 && r == 1, "R3 strobe width zero", h * 10 + r, 11);
        trial(2, 5, 16'h0, 16'h1, 1'b0, 1'b0, h, r);
        check(h == 1 && r == 1, "R3 strobe follow", h * 10 + r, 11);

        // R10: strobe ORed with request
        trial(0, 4, 16'h1, 16'h1, 1'b0, 1'b0, h, r);
        check(h == 4 && r == 1, "R10 overlap fixed", h * 10 + r, 41);
        trial(1, 7, 16'h1, 16'h1, 1'b0, 1'b0, h, r);
        check(h == 2 && r == 1, "R10 adjacent capped", h * 10 + r, 21);

        // R5 R9: gating
        for (int m = 0; m < 3; m++) begin
            trial(m, 5, 16'b111, 16'h0, 1'b0, 1'b1, h, r);
            check(h == 0, "R5 software gate", h, 0);
            trial(m, 5, 16'b111, 16'h0, 1'b1, 1'b0, h, r);
            check(h == ((m == 2) ? 3 : 0), (m == 2) ? "R9 ext gate ignored" : "R5 ext gate", h, (m == 2) ? 3 : 0);
        end
        trial(0, 3, 16'h0, 16'h1, 1'b0, 1'b1, h, r);
        check(h == 0, "R5 gate blocks strobe", h, 0);

        // R4: strobe readback
        @(negedge clk);
        sw_wr = 1'b1;
        @(negedge clk);
        check(rd == 1'b1, "R4 readback set", int'(rd), 1);
        sw_wr = 1'b0;
        @(negedge clk);
        check(rd == 1'b0, "R4 readback cleared", int'(rd), 0);
        @(negedge clk);
        check(rd == 1'b0, "R4 readback stays 0", int'(rd), 0);
        repeat (10) @(negedge clk);

        // R1 R2: pin encoding sweep in follow mode
        tbase = 1'b1;
        orig = 1'b1;
        for (int lvl = 0; lvl < 2; lvl++) begin
            for (int s = 0; s < 4; s++) begin
                for (int d = 0; d < 2; d++) begin
                    bit eu_oe, eu_o, em_oe, em_o;
                    @(negedge clk);
                    upd_req = lvl[0];
                    out_sel = 2'(s);
                    mp_dir = d[0];
                    repeat (2) @(negedge clk);
                    eu_oe = (s != 0);
                    eu_o = (s == 3) ? lvl[0] : (s == 2) ? !lvl[0] : 1'b0;
                    em_oe = d[0];
                    em_o = !d[0] ? 1'b0 : (s == 1) ? 1'b0 : (s == 3) ? lvl[0] : !lvl[0];
                    check(upd_oe == eu_oe, "R1 upd enable", int'(upd_oe), int'(eu_oe));
                    check(upd_o == eu_o, "R1 upd level", int'(upd_o), int'(eu_o));
                    check(mp_oe == em_oe, "R2 mp enable", int'(mp_oe), int'(em_oe));
                    check(mp_o == em_o, "R2 mp level", int'(mp_o), int'(em_o));
                end
            end
        end
        upd_req = 1'b0;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule